// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block sequences a microprogrammed control unit. A control address register selects a word of an internal control memory, and that word is held in a control buffer register for the cycle in which it acts. Each word uses one of two formats, chosen by its top bit. A control word drives its low bits straight out as datapath control signals, and sequencing then moves on to the next address. A branch word drives no control signals. Instead it names a condition and a target address.

At every rising edge the sequencer picks the next control address from one of three sources. The first is the current address plus one. The second is the target field of the branch word. The third is a routine entry derived from the machine-instruction opcode. The choice depends on the format bit, the condition code, the ALU flags and an interrupt-pending input. The following word is read from the control memory in the same cycle that its address is chosen, so one microinstruction issues on every clock.

The control memory is a synthesizable ROM. Its contents come from a function, and it holds four parts:
- a fetch routine starting at address 0;
- an interrupt-entry routine at address 0x10;
- one four-word routine for each opcode, placed at the dispatch addresses;
- a branch back to the fetch routine at every other address.

Top module: `useq_top`

## Requirements
- R1: A low `rst_n` sampled at a rising edge puts `uaddr` at 0 and loads the word at address 0 into the control buffer. That word is a control word whose outputs are 12'h001, so `ctrl_out` reads 12'h001.
- R2: In a control-format word (bit 12 = 0), `ctrl_out` equals bits 11:0 of the word. At the next edge `uaddr` becomes the current address plus one, so one new microinstruction takes effect on every edge.
- R3: A branch-format word (bit 12 = 1) keeps `ctrl_out` at zero. Its condition code sits in bits 9:7 and its target address in bits 6:0.
- R4: Condition code 0 always jumps to the target. Condition code 7 never jumps and moves on to the current address plus one.
- R5: The flag conditions are codes 1 (zero, `flags[0]`), 2 (carry, `flags[1]`), 3 (negative, `flags[2]`) and 4 (overflow, `flags[3]`). When the selected flag is 1 the sequencer jumps to the target. When it is 0 the sequencer moves to the current address plus one.
- R6: Condition code 5 jumps when `irq_pend` is 1 and moves to the current address plus one when it is 0.
- R7: Condition code 6 ignores the target field and jumps to the address {1'b1, opcode, 2'b00}. Each opcode routine therefore owns a four-word slot.
- R8: The ROM holds the following program:

| Address | Word type | Contents |
|---|---|---|
| 0 | Control | 12'h001 |
| 1 | Control | 12'h006 |
| 2 | Control | 12'h008 |
| 3 | Branch | Condition 5, target 0x10 |
| 4 | Branch | Condition 6 |
| 0x10 | Control | 12'h020 |
| 0x11 | Control | 12'h040 |
| Slot word 0 | Control | 12'h100 OR opcode |
| Slot word 1 | Branch | Condition opcode[2:0], target slot word 3 |
| Slot word 2 | Control | 12'h200 OR opcode |
| Every other address | Branch | Condition 0, target 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| flags | input | 4 | ALU flags: bit 0 zero, bit 1 carry, bit 2 negative, bit 3 overflow |
| irq_pend | input | 1 | Interrupt request pending |
| opcode | input | OPW (4) | Opcode field of the instruction register |
| ctrl_out | output | CW (12) | Control signals of the current microinstruction |
| uaddr | output | AW (7) | Current control address |

## Verification
The bench builds the block with AW = 7, CW = 12 and OPW = 4. With these values the dispatch address fills the upper half of the 128-word control memory, and every opcode slot lies at a distinct, predictable address. A traced run therefore reaches every condition code through the routines of opcodes 1, 2, 3, 4, 6 and 7. Those traces cover taken and not-taken outcomes, the never code, and a second dispatch made from inside a routine with a different opcode, followed by a reset taken in the middle of a run.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    C_ALWAYS   = 3'd0,
    C_ZERO     = 3'd1,
    C_CARRY    = 3'd2,
    C_NEG      = 3'd3,
    C_OVF      = 3'd4,
    C_IRQ      = 3'd5,
    C_DISPATCH = 3'd6,
    C_NEVER    = 3'd7
  } cond_e;

  localparam int COND_W = 3;
  localparam int FLAG_W = 4;

  // Flag bit positions inside the flags vector
  localparam int F_Z = 0;
  localparam int F_C = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;

  // Evaluate a branch condition; dispatch and never report not-met here
  function automatic logic cond_met(cond_e c, logic [FLAG_W-1:0] flg, logic irq);
    logic r;
    case (c)
      C_ALWAYS: r = 1'b1;
      C_ZERO:   r = flg[F_Z];
      C_CARRY:  r = flg[F_C];
      C_NEG:    r = flg[F_N];
      C_OVF:    r = flg[F_V];
      C_IRQ:    r = irq;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int CW  = 12,
  parameter int OPW = 4
) (
  input  logic [AW-1:0] addr,
  output logic [CW:0]   word
);

  localparam int SW = AW - 1 - OPW;
  localparam logic [AW-1:0] IRQ_BASE = AW'(16);
  localparam logic [AW-1:0] IRQ_NEXT = AW'(17);

  function automatic logic [CW:0] ctl(logic [CW-1:0] sig);
    return {1'b0, sig};
  endfunction

  function automatic logic [CW:0] br(cond_e c, logic [AW-1:0] tgt);
    logic [CW:0] w;
    w = '0;
    w[CW] = 1'b1;
    w[AW+COND_W-1:AW] = c;
    w[AW-1:0] = tgt;
    return w;
  endfunction

  function automatic logic [CW:0] rom_at(logic [AW-1:0] a);
    logic [OPW-1:0] op;
    logic [SW-1:0]  off;
    logic [CW:0]    w;
    op  = a[AW-2 -: OPW];
    off = a[SW-1:0];
    if (a[AW-1]) begin
      if (off == SW'(0))      w = ctl(CW'(12'h100) | CW'(op));
      else if (off == SW'(1)) w = br(cond_e'(op[COND_W-1:0]), {a[AW-1:SW], {SW{1'b1}}});
      else if (off == SW'(2)) w = ctl(CW'(12'h200) | CW'(op));
      else                    w = br(C_ALWAYS, '0);
    end else begin
      case (a)
        AW'(0):   w = ctl(CW'(12'h001));
        AW'(1):   w = ctl(CW'(12'h006));
        AW'(2):   w = ctl(CW'(12'h008));
        AW'(3):   w = br(C_IRQ, IRQ_BASE);
        AW'(4):   w = br(C_DISPATCH, '0);
        IRQ_BASE: w = ctl(CW'(12'h020));
        IRQ_NEXT: w = ctl(CW'(12'h040));
        default:  w = br(C_ALWAYS, '0);
      endcase
    end
    return w;
  endfunction

  assign word = rom_at(addr);

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int CW  = 12,
  parameter int OPW = 4
) (
  input  logic [AW-1:0]     car,
  input  logic [CW:0]       word,
  input  logic [FLAG_W-1:0] flags,
  input  logic              irq,
  input  logic [OPW-1:0]    opcode,
  output logic [AW-1:0]     nxt,
  output logic              is_branch,
  output logic              taken,
  output logic              dispatch,
  output cond_e             cond,
  output logic [AW-1:0]     target
);

  localparam int SW = AW - 1 - OPW;

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] slot_addr(logic [OPW-1:0] op);
    return {1'b1, op, {SW{1'b0}}};
  endfunction

  always_comb begin
    is_branch = word[CW];
    cond      = cond_e'(word[AW+COND_W-1:AW]);
    target    = word[AW-1:0];
    dispatch  = is_branch && (cond == C_DISPATCH);
    taken     = is_branch && cond_met(cond, flags, irq);
    if (dispatch)   nxt = slot_addr(opcode);
    else if (taken) nxt = target;
    else            nxt = seq_addr(car);
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW  = 7,
  parameter int CW  = 12,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     flags,
  input  logic           irq_pend,
  input  logic [OPW-1:0] opcode,
  output logic [CW-1:0]  ctrl_out,
  output logic [AW-1:0]  uaddr
);

  localparam int SW = AW - 1 - OPW;

  logic [AW-1:0] car;
  logic [CW:0]   cbr;
  logic [AW-1:0] nxt;
  logic [AW-1:0] rom_addr;
  logic [CW:0]   rom_word;
  logic          is_branch;
  logic          taken;
  logic          dispatch;
  cond_e         cond;
  logic [AW-1:0] target;

  useq_next #(.AW(AW), .CW(CW), .OPW(OPW)) u_next (
    .car(car), .word(cbr), .flags(flags), .irq(irq_pend), .opcode(opcode),
    .nxt(nxt), .is_branch(is_branch), .taken(taken), .dispatch(dispatch),
    .cond(cond), .target(target)
  );

  assign rom_addr = rst_n ? nxt : '0;

  useq_rom #(.AW(AW), .CW(CW), .OPW(OPW)) u_rom (
    .addr(rom_addr), .word(rom_word)
  );

  always_ff @(posedge clk) begin
    car <= rom_addr;
    cbr <= rom_word;
  end

  assign ctrl_out = cbr[CW] ? '0 : cbr[CW-1:0];
  assign uaddr    = car;

  // R1
  reset_load_chk: assert property (@(posedge clk)
    !rst_n |=> (uaddr == '0) && (ctrl_out == CW'(1)));

  // R2
  ctrl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |=> uaddr == $past(uaddr) + AW'(1));

  // R3
  branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> ctrl_out == '0);

  // R4
  never_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && cond == C_NEVER) |=> uaddr == $past(uaddr) + AW'(1));

  // R4
  always_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && cond == C_ALWAYS) |=> uaddr == $past(target));

  // R5
  taken_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> uaddr == $past(target));

  // R5
  untaken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !taken && !dispatch) |=> uaddr == $past(uaddr) + AW'(1));

  // R7
  dispatch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> uaddr == {1'b1, $past(opcode), {SW{1'b0}}});

endmodule

// File: tb/test_useq_top.sv
module test_useq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] flags = 4'h0;
  logic       irq_pend = 1'b0;
  logic [3:0] opcode = 4'h0;
  logic [11:0] ctrl_out;
  logic [6:0]  uaddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst_n(rst_n), .flags(flags), .irq_pend(irq_pend),
    .opcode(opcode), .ctrl_out(ctrl_out), .uaddr(uaddr)
  );

  // {irq, flags{v,n,c,z}, opcode, expected uaddr, expected ctrl_out}
  localparam int NV = 51;
  localparam logic [27:0] VEC [NV] = '{
    // opcode 3: fetch (R8), irq not pending (R6), dispatch (R7), negative taken (R5)
    {1'b0,4'h4,4'h3,7'h01,12'h006},
    {1'b0,4'h4,4'h3,7'h02,12'h008},
    {1'b0,4'h4,4'h3,7'h03,12'h000},
    {1'b0,4'h4,4'h3,7'h04,12'h000},
    {1'b0,4'h4,4'h3,7'h4C,12'h103},
    {1'b0,4'h4,4'h3,7'h4D,12'h000},
    {1'b0,4'h4,4'h3,7'h4F,12'h000},
    {1'b0,4'h4,4'h3,7'h00,12'h001},
    // interrupt taken at address 3 (R6), always-branch back (R4), control steps (R2)
    {1'b1,4'h0,4'h0,7'h01,12'h006},
    {1'b1,4'h0,4'h0,7'h02,12'h008},
    {1'b1,4'h0,4'h0,7'h03,12'h000},
    {1'b1,4'h0,4'h0,7'h10,12'h020},
    {1'b1,4'h0,4'h0,7'h11,12'h040},
    {1'b1,4'h0,4'h0,7'h12,12'h000},
    {1'b1,4'h0,4'h0,7'h00,12'h001},
    // opcode 1: zero clear, not taken (R5), branch word quiet (R3)
    {1'b0,4'h0,4'h1,7'h01,12'h006},
    {1'b0,4'h0,4'h1,7'h02,12'h008},
    {1'b0,4'h0,4'h1,7'h03,12'h000},
    {1'b0,4'h0,4'h1,7'h04,12'h000},
    {1'b0,4'h0,4'h1,7'h44,12'h101},
    {1'b0,4'h0,4'h1,7'h45,12'h000},
    {1'b0,4'h0,4'h1,7'h46,12'h201},
    {1'b0,4'h0,4'h1,7'h47,12'h000},
    {1'b0,4'h0,4'h1,7'h00,12'h001},
    // opcode 7: never code with all flags set (R4)
    {1'b0,4'hF,4'h7,7'h01,12'h006},
    {1'b0,4'hF,4'h7,7'h02,12'h008},
    {1'b0,4'hF,4'h7,7'h03,12'h000},
    {1'b0,4'hF,4'h7,7'h04,12'h000},
    {1'b0,4'hF,4'h7,7'h5C,12'h107},
    {1'b0,4'hF,4'h7,7'h5D,12'h000},
    {1'b0,4'hF,4'h7,7'h5E,12'h207},
    {1'b0,4'hF,4'h7,7'h5F,12'h000},
    {1'b0,4'hF,4'h7,7'h00,12'h001},
    // opcode 6 re-dispatches with opcode 2 (R7), then carry taken (R5)
    {1'b0,4'h2,4'h6,7'h01,12'h006},
    {1'b0,4'h2,4'h6,7'h02,12'h008},
    {1'b0,4'h2,4'h6,7'h03,12'h000},
    {1'b0,4'h2,4'h6,7'h04,12'h000},
    {1'b0,4'h2,4'h6,7'h58,12'h106},
    {1'b0,4'h2,4'h6,7'h59,12'h000},
    {1'b0,4'h2,4'h2,7'h48,12'h102},
    {1'b0,4'h2,4'h2,7'h49,12'h000},
    {1'b0,4'h2,4'h2,7'h4B,12'h000},
    {1'b0,4'h2,4'h2,7'h00,12'h001},
    // opcode 4: overflow taken (R5)
    {1'b0,4'h8,4'h4,7'h01,12'h006},
    {1'b0,4'h8,4'h4,7'h02,12'h008},
    {1'b0,4'h8,4'h4,7'h03,12'h000},
    {1'b0,4'h8,4'h4,7'h04,12'h000},
    {1'b0,4'h8,4'h4,7'h50,12'h104},
    {1'b0,4'h8,4'h4,7'h51,12'h000},
    {1'b0,4'h8,4'h4,7'h53,12'h000},
    {1'b0,4'h8,4'h4,7'h00,12'h001}
  };

  task automatic check(input string tag, input logic [6:0] ea, input logic [11:0] ec);
    n_run++;
    if (uaddr !== ea || ctrl_out !== ec) begin
      n_fail++;
      $display("FAIL %s: uaddr=%h ctrl_out=%h expected uaddr=%h ctrl_out=%h",
               tag, uaddr, ctrl_out, ea, ec);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 7'h00, 12'h001);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      irq_pend = VEC[i][27];
      flags    = VEC[i][26:23];
      opcode   = VEC[i][22:19];
      @(negedge clk);
      check($sformatf("table step %0d", i), VEC[i][18:12], VEC[i][11:0]);
    end
    // Reset taken in mid-run, from a fetch address (R1)
    irq_pend = 1'b0;
    flags = 4'h0;
    opcode = 4'h0;
    @(negedge clk);
    check("R2 step after table", 7'h01, 12'h006);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 7'h00, 12'h001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 restart after reset", 7'h01, 12'h006);
    @(negedge clk);
    check("R8 fetch word 2", 7'h02, 12'h008);
    finish_run();
  end

endmodule